// File: doc/BRIEF.md
# Multi-Mode 8-Bit PWM Timer

An 8-bit counter advanced by an external count-enable tick, with a waveform generator that drives two compare output channels. A 3-bit mode field selects one of six counting schemes: free-running, clear-on-compare (CTC), single-slope fast PWM and dual-slope phase-correct PWM. The last two each come with TOP fixed at 0xFF or taken from the channel-A compare value. The mode also sets when new compare values become active and at which count the overflow flag rises.

Software reaches the block through a small register port: a control byte, the count, the two compare values, and a flag byte whose bits are cleared by writing one. Each channel has a 2-bit output setting. Each channel has a registered wave level and an enable that says whether the pin is driven by the timer. All events are taken from the count held during the tick cycle. Their effects show one clock later.

Top module: `pwm_timer8`

## Requirements
- R1: Register map (3-bit address): 0 = control {cfgB[7:6], cfgA[5:4], reserved bit 3, mode[2:0]}, 1 = count, 2 = compare A, 3 = compare B, 4 = flags {matchB[2], matchA[1], overflow[0]}. Reads of 2 and 3 return the last written compare value. Control bit 3, flag bits 7:3 and addresses 5 to 7 read as zero. Reset clears everything.
- R2: Mode 0 (normal): each tick adds one to the count, wrapping 0xFF to 0x00. Without a tick the count holds. A count write overrides the tick.
- R3: Mode 2 (CTC): TOP is compare A, and a tick while the count equals TOP loads 0x00. Otherwise the count rises by one.
- R4: Modes 3 and 7 (fast PWM, TOP 0xFF or compare A): a tick at TOP loads 0x00, and any other tick adds one.
- R5: Modes 1 and 5 (phase-correct, TOP 0xFF or compare A): the counter is "rising" when the count is 0x00, or when the direction is up and the count is below TOP. A tick adds one when rising and subtracts one otherwise. The direction turns down at TOP and up at 0x00, so each end is held for exactly one tick.
- R6: Compare writes become active at once in modes 0 and 2. In PWM modes the written value waits and becomes active on the tick at TOP, so the period in progress keeps the old TOP.
- R7: The overflow flag is set on a tick at count 0xFF in modes 0 and 2, at 0x00 in phase-correct modes, and at TOP in fast PWM modes. Writing one to flag bit 0 clears it, and a set in the same cycle wins.
- R8: A channel's match flag is set on a tick where the count equals that channel's active compare value. It clears when one is written to its flag bit.
- R9: In modes 0 and 2, on a match, output setting 01 toggles the wave, 10 clears it and 11 sets it. Setting 00 leaves the wave and deasserts the enable.
- R10: In fast PWM, setting 10 sets the wave on the tick at TOP and clears it on a match, with the TOP action winning. Setting 11 is the inverse. 00 and 01 deassert the enable and leave the wave alone.
- R11: In phase-correct mode, a match with setting 10 clears the wave while rising and sets it while falling, and setting 11 does the opposite. 00 and 01 deassert the enable.
- R12: In phase-correct mode with the upper setting bit high, when a channel's compare value equals TOP, the match rule is replaced on the TOP tick: the wave is set for 10 and cleared for 11.
- R13: Modes 4 and 6 are reserved. Ticks leave the count, both waves and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from an external prescaler |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| ovfFlag | output | 1 | Overflow flag |
| matchFlagA | output | 1 | Channel A match flag |
| matchFlagB | output | 1 | Channel B match flag |
| waveA | output | 1 | Channel A wave level |
| waveB | output | 1 | Channel B wave level |
| driveA | output | 1 | Channel A pin enable |
| driveB | output | 1 | Channel B pin enable |

## Verification
The bench builds the block with its default 8-bit count width. Whole periods are then short, a 0xFF-TOP cycle lasts at most 510 ticks, and both the 0x00 and 0xFF ends are visited many times within a few thousand clocks. Random runs with a compare-A TOP push small and zero TOP values through the phase-correct turn-around and the compare-equals-TOP rule. Reserved modes and mid-period compare writes are mixed into the same runs.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int NUM_CH = 2;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_CMPA  = 3'd2;
  localparam logic [2:0] ADDR_FLAGS = 3'd4;

  localparam logic [7:0] CTRL_WRITE_MASK = 8'hF7;

  typedef enum logic [2:0] {
    CLS_NORMAL,
    CLS_CTC,
    CLS_FAST,
    CLS_PHASE,
    CLS_HOLD
  } modeCls_t;

  typedef struct packed {
    modeCls_t cls;
    logic     tickOk;
    logic     stepUp;
    logic     stepDown;
    logic     toZero;
    logic     latchBuf;
    logic     immediate;
    logic     ovfSet;
    logic     edgeTop;
    logic     upPhase;
  } strobe_t;

  function automatic modeCls_t decodeMode(input logic [2:0] m);
    case (m)
      3'd0:        return CLS_NORMAL;
      3'd2:        return CLS_CTC;
      3'd3, 3'd7:  return CLS_FAST;
      3'd1, 3'd5:  return CLS_PHASE;
      default:     return CLS_HOLD;
    endcase
  endfunction

  function automatic logic topFromCmpA(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
  endfunction

endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] cmpActA,
  output logic [DW-1:0] topVal,
  output strobe_t       strb
);

  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  logic     dirUp;
  modeCls_t cls;
  logic     tickOk, atTop, atBot, upPhase;

  always_comb begin
    cls     = decodeMode(mode);
    topVal  = topFromCmpA(mode) ? cmpActA : MAXV;
    tickOk  = tick && (cls != CLS_HOLD);
    atTop   = (cnt == topVal);
    atBot   = (cnt == '0);
    upPhase = atBot || (dirUp && (cnt < topVal));

    strb           = '0;
    strb.cls       = cls;
    strb.tickOk    = tickOk;
    strb.upPhase   = upPhase;
    strb.immediate = (cls == CLS_NORMAL) || (cls == CLS_CTC);
    strb.edgeTop   = tickOk && atTop;
    strb.latchBuf  = tickOk && atTop && ((cls == CLS_FAST) || (cls == CLS_PHASE));

    if (tickOk) begin
      case (cls)
        CLS_NORMAL: begin
          strb.stepUp = 1'b1;
          strb.ovfSet = (cnt == MAXV);
        end
        CLS_CTC: begin
          strb.toZero = atTop;
          strb.stepUp = !atTop;
          strb.ovfSet = (cnt == MAXV);
        end
        CLS_FAST: begin
          strb.toZero = atTop;
          strb.stepUp = !atTop;
          strb.ovfSet = atTop;
        end
        CLS_PHASE: begin
          strb.stepUp   = upPhase;
          strb.stepDown = !upPhase;
          strb.ovfSet   = atBot;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirUp <= 1'b1;
    end else if (cls != CLS_PHASE) begin
      dirUp <= 1'b1;
    end else if (tickOk) begin
      if (atBot)              dirUp <= 1'b1;
      else if (cnt >= topVal) dirUp <= 1'b0;
    end
  end

  // R5: a phase-correct tick at a nonzero TOP turns the direction downward
  assert_turn_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode(mode) == CLS_PHASE && tick && cnt == topVal && cnt != '0) |=> !dirUp);

  // R5: a phase-correct tick at BOTTOM turns the direction upward
  assert_turn_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode(mode) == CLS_PHASE && tick && cnt == '0) |=> dirUp);

endmodule

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DW-1:0]     wrData,
  input  strobe_t           strb,
  input  logic [DW-1:0]     topVal,
  output logic [DW-1:0]     rdData,
  output logic [DW-1:0]     cnt,
  output logic [DW-1:0]     cmpActA,
  output logic [2:0]        mode,
  output logic              ovfFlag,
  output logic [NUM_CH-1:0] matchFlag,
  output logic [NUM_CH-1:0] wave,
  output logic [NUM_CH-1:0] drive
);

  logic [7:0]    ctrlReg;
  logic [DW-1:0] cmpBuf [NUM_CH];
  logic [DW-1:0] cmpAct [NUM_CH];
  logic          cntWr, ctrlWr, flagWr, pwmMode;

  assign cntWr   = wrEn && (addr == ADDR_COUNT);
  assign ctrlWr  = wrEn && (addr == ADDR_CTRL);
  assign flagWr  = wrEn && (addr == ADDR_FLAGS);
  assign mode    = ctrlReg[2:0];
  assign cmpActA = cmpAct[0];
  assign pwmMode = (strb.cls == CLS_FAST) || (strb.cls == CLS_PHASE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cnt     <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= wrData[7:0] & CTRL_WRITE_MASK;
      if (cntWr)              cnt <= wrData;
      else if (strb.toZero)   cnt <= '0;
      else if (strb.stepUp)   cnt <= cnt + 1'b1;
      else if (strb.stepDown) cnt <= cnt - 1'b1;
      ovfFlag <= strb.ovfSet || (ovfFlag && !(flagWr && wrData[0]));
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [1:0] cfg;
    logic       cmpWr, match;

    assign cfg       = ctrlReg[4 + 2*ch +: 2];
    assign cmpWr     = wrEn && (addr == ADDR_CMPA + 3'(ch));
    assign match     = strb.tickOk && (cnt == cmpAct[ch]);
    assign drive[ch] = (cfg != 2'b00) && !(pwmMode && cfg == 2'b01);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpBuf[ch]    <= '0;
        cmpAct[ch]    <= '0;
        matchFlag[ch] <= 1'b0;
        wave[ch]      <= 1'b0;
      end else begin
        if (cmpWr) cmpBuf[ch] <= wrData;
        if (cmpWr && strb.immediate) cmpAct[ch] <= wrData;
        else if (strb.latchBuf)      cmpAct[ch] <= cmpBuf[ch];

        matchFlag[ch] <= match || (matchFlag[ch] && !(flagWr && wrData[1+ch]));

        case (strb.cls)
          CLS_NORMAL, CLS_CTC: begin
            if (match) begin
              case (cfg)
                2'b01:   wave[ch] <= !wave[ch];
                2'b10:   wave[ch] <= 1'b0;
                2'b11:   wave[ch] <= 1'b1;
                default: ;
              endcase
            end
          end
          CLS_FAST: begin
            if (cfg[1]) begin
              if (strb.edgeTop) wave[ch] <= !cfg[0];
              else if (match)   wave[ch] <= cfg[0];
            end
          end
          CLS_PHASE: begin
            if (cfg[1]) begin
              if (strb.edgeTop && cmpAct[ch] == topVal) wave[ch] <= !cfg[0];
              else if (match) wave[ch] <= strb.upPhase ? cfg[0] : !cfg[0];
            end
          end
          default: ;
        endcase
      end
    end

    // R12: compare value at TOP with setting 10 leaves the wave high after the TOP tick
    assert_top_rule_R12: assert property (@(posedge clk) disable iff (!rstN)
      (strb.cls == CLS_PHASE && strb.edgeTop && cmpAct[ch] == topVal && cfg == 2'b10)
      |=> wave[ch]);

    // R8: a tick on the compare value raises the channel flag
    assert_match_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tickOk && cnt == cmpAct[ch]) |=> matchFlag[ch]);
  end

  always_comb begin
    case (addr)
      ADDR_CTRL:  rdData = DW'(ctrlReg);
      ADDR_COUNT: rdData = cnt;
      3'd2:       rdData = cmpBuf[0];
      3'd3:       rdData = cmpBuf[1];
      ADDR_FLAGS: rdData = DW'({matchFlag[1], matchFlag[0], ovfFlag});
      default:    rdData = '0;
    endcase
  end

  // R7: an overflow event is visible on the flag one clock later
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.ovfSet |=> ovfFlag);

  // R3: CTC tick at TOP returns the count to zero
  assert_ctc_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cls == CLS_CTC && strb.tickOk && cnt == topVal && !cntWr) |=> cnt == '0);

  // R13: reserved modes freeze the count
  assert_hold_count_R13: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cls == CLS_HOLD && !cntWr) |=> cnt == $past(cnt));

  // R5: falling from a nonzero TOP steps down by one
  assert_phase_turn_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cls == CLS_PHASE && strb.tickOk && cnt == topVal && cnt != '0 && !cntWr)
    |=> cnt == DW'($past(cnt) - 1'b1));

  // R1: the reserved control bit always reads back as zero
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_CTRL) |-> (rdData[3] == 1'b0));

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          ovfFlag,
  output logic          matchFlagA,
  output logic          matchFlagB,
  output logic          waveA,
  output logic          waveB,
  output logic          driveA,
  output logic          driveB
);

  strobe_t           strb;
  logic [DW-1:0]     cnt, cmpActA, topVal;
  logic [2:0]        mode;
  logic [NUM_CH-1:0] matchFlag, wave, drive;

  pwmt_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .mode(mode), .cnt(cnt),
    .cmpActA(cmpActA), .topVal(topVal), .strb(strb)
  );

  pwmt_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .topVal(topVal), .rdData(rdData), .cnt(cnt),
    .cmpActA(cmpActA), .mode(mode), .ovfFlag(ovfFlag),
    .matchFlag(matchFlag), .wave(wave), .drive(drive)
  );

  assign matchFlagA = matchFlag[0];
  assign matchFlagB = matchFlag[1];
  assign waveA      = wave[0];
  assign waveB      = wave[1];
  assign driveA     = drive[0];
  assign driveB     = drive[1];

endmodule

// File: tb/sim_pwm_timer8.sv
module sim_pwm_timer8;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ovfFlag, matchFlagA, matchFlagB, waveA, waveB, driveA, driveB;

  int nChecks = 0;
  int nFails  = 0;

  pwm_timer8 #(.DW(8)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ovfFlag(ovfFlag), .matchFlagA(matchFlagA), .matchFlagB(matchFlagB),
    .waveA(waveA), .waveB(waveB), .driveA(driveA), .driveB(driveB)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  // reference model state
  logic [7:0] mCtrl, mCnt;
  logic [7:0] mBuf [2];
  logic [7:0] mAct [2];
  logic       mDir, mOvf;
  logic [1:0] mMf, mOc;

  task automatic modelStep(input logic we, input logic [2:0] a, input logic [7:0] d, input logic tk);
    logic [2:0] md;
    logic hold, fastM, phaseM, plainM, ok, atTop, atBot, up, nDir, nOvf, match;
    logic [7:0] top, nCnt, nCtrl;
    logic [7:0] nBuf [2];
    logic [7:0] nAct [2];
    logic [1:0] nMf, nOc, cfg;
    md     = mCtrl[2:0];
    hold   = (md == 4) || (md == 6);
    fastM  = (md == 3) || (md == 7);
    phaseM = (md == 1) || (md == 5);
    plainM = (md == 0) || (md == 2);
    top    = (md == 2 || md == 5 || md == 7) ? mAct[0] : 8'hFF;
    ok     = tk && !hold;
    atTop  = (mCnt == top);
    atBot  = (mCnt == 0);
    up     = atBot || (mDir && mCnt < top);
    nCnt = mCnt; nDir = mDir; nCtrl = mCtrl;
    if (!phaseM) nDir = 1'b1;
    if (ok) begin
      if (md == 0)                nCnt = mCnt + 8'd1;
      else if (md == 2 || fastM)  nCnt = atTop ? 8'd0 : mCnt + 8'd1;
      else                        nCnt = up ? mCnt + 8'd1 : mCnt - 8'd1;
      if (phaseM) begin
        if (atBot) nDir = 1'b1;
        else if (mCnt >= top) nDir = 1'b0;
      end
    end
    nOvf = ok && (plainM ? (mCnt == 8'hFF) : phaseM ? atBot : atTop);
    nOvf = nOvf || (mOvf && !(we && a == 4 && d[0]));
    for (int ch = 0; ch < 2; ch++) begin
      cfg   = mCtrl[4 + 2*ch +: 2];
      match = ok && (mCnt == mAct[ch]);
      nOc[ch] = mOc[ch];
      if (ok) begin
        if (plainM && match) begin
          if (cfg == 2'b01) nOc[ch] = !mOc[ch];
          else if (cfg == 2'b10) nOc[ch] = 1'b0;
          else if (cfg == 2'b11) nOc[ch] = 1'b1;
        end else if (fastM && cfg[1]) begin
          if (atTop) nOc[ch] = !cfg[0];
          else if (match) nOc[ch] = cfg[0];
        end else if (phaseM && cfg[1]) begin
          if (atTop && mAct[ch] == top) nOc[ch] = !cfg[0];
          else if (match) nOc[ch] = up ? cfg[0] : !cfg[0];
        end
      end
      nBuf[ch] = mBuf[ch];
      nAct[ch] = mAct[ch];
      if (ok && (fastM || phaseM) && atTop) nAct[ch] = mBuf[ch];
      if (we && a == 3'(2 + ch)) begin
        nBuf[ch] = d;
        if (plainM) nAct[ch] = d;
      end
      nMf[ch] = match || (mMf[ch] && !(we && a == 4 && d[1+ch]));
    end
    if (we && a == 1) nCnt = d;
    if (we && a == 0) nCtrl = d & 8'hF7;
    mCtrl = nCtrl; mCnt = nCnt; mDir = nDir; mOvf = nOvf; mMf = nMf; mOc = nOc;
    for (int ch = 0; ch < 2; ch++) begin mBuf[ch] = nBuf[ch]; mAct[ch] = nAct[ch]; end
  endtask

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd1: return mCnt;
      3'd2: return mBuf[0];
      3'd3: return mBuf[1];
      3'd4: return {5'b0, mMf[1], mMf[0], mOvf};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mDrive(input int ch);
    logic [1:0] cfg;
    logic pwm;
    cfg = mCtrl[4 + 2*ch +: 2];
    pwm = mCtrl[0];
    pwm = (mCtrl[2:0] == 1) || (mCtrl[2:0] == 3) || (mCtrl[2:0] == 5) || (mCtrl[2:0] == 7);
    return (cfg != 2'b00) && !(pwm && cfg == 2'b01);
  endfunction

  function automatic string countReq(input logic [2:0] md);
    case (md)
      3'd0: return "R2";
      3'd2: return "R3";
      3'd3, 3'd7: return "R4";
      3'd1, 3'd5: return "R5";
      default: return "R13";
    endcase
  endfunction

  function automatic string waveReq(input logic [2:0] md);
    case (md)
      3'd0, 3'd2: return "R9";
      3'd3, 3'd7: return "R10";
      3'd1, 3'd5: return "R11";
      default: return "R13";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mCnt = 0; mDir = 1; mOvf = 0; mMf = 0; mOc = 0;
      for (int ch = 0; ch < 2; ch++) begin mBuf[ch] = 0; mAct[ch] = 0; end
    end else begin
      modelStep(wrEn, addr, wrData, tick);
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compareModel();
    if (rstN) begin
      chk(countReq(mCtrl[2:0]), 32'(rdData), 32'(mRead(addr)));
      chk("R7/R8 flags", {29'd0, matchFlagB, matchFlagA, ovfFlag}, {29'd0, mMf[1], mMf[0], mOvf});
      chk(waveReq(mCtrl[2:0]), {28'd0, driveB, driveA, waveB, waveA},
          {28'd0, mDrive(1), mDrive(0), mOc[1], mOc[0]});
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d, input logic tk);
    wrEn = we; addr = a; wrData = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    compareModel();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd1, 8'h00, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: got running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic w0;
    logic [7:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    step(0, 3'd0, 0, 0); chk("R1 reset ctrl", 32'(rdData), 0);
    step(0, 3'd4, 0, 0); chk("R1 reset flags", 32'(rdData), 0);
    chk("R1 reset wave", {30'd0, waveB, waveA}, 0);
    chk("R9 reset enable", {30'd0, driveB, driveA}, 0);

    // R1 reserved bits and unused addresses
    step(1, 3'd0, 8'hFF, 0);
    step(0, 3'd0, 0, 0); chk("R1 ctrl bit3 zero", 32'(rdData), 32'hF7);
    step(0, 3'd5, 0, 0); chk("R1 unused addr", 32'(rdData), 0);

    // R2 wrap and R7 overflow
    step(1, 3'd0, 8'h00, 0);
    step(1, 3'd1, 8'hFE, 0);
    step(1, 3'd4, 8'h07, 0);
    ticks(1); chk("R2 count", 32'(rdData), 32'hFF);
    ticks(1); chk("R2 wrap", 32'(rdData), 0);
    chk("R7 ovf at MAX", 32'(ovfFlag), 1);
    step(1, 3'd4, 8'h01, 0); chk("R7 w1c", 32'(ovfFlag), 0);
    step(0, 3'd1, 0, 0); chk("R2 no tick holds", 32'(rdData), 0);

    // R3 CTC and R8 match flag
    step(1, 3'd0, 8'h02, 0);
    step(1, 3'd2, 8'd5, 0);
    step(1, 3'd1, 8'd0, 0);
    step(1, 3'd4, 8'h07, 0);
    ticks(5); chk("R3 at TOP", 32'(rdData), 5);
    ticks(1); chk("R3 clear", 32'(rdData), 0);
    chk("R8 flag A", 32'(matchFlagA), 1);

    // R9 toggle in normal mode
    step(1, 3'd0, 8'h10, 0);
    step(1, 3'd2, 8'd2, 0);
    step(1, 3'd1, 8'd0, 0);
    w0 = waveA;
    ticks(3); chk("R9 toggle", 32'(waveA), 32'(!w0));

    // R5 dual slope and R12 compare equals TOP
    step(1, 3'd0, 8'h02, 0);
    step(1, 3'd2, 8'd3, 0);
    step(1, 3'd1, 8'd0, 0);
    step(1, 3'd0, 8'h35, 0);
    ticks(4); chk("R5 turn at TOP", 32'(rdData), 2);
    chk("R12 clear at TOP", 32'(waveA), 0);
    ticks(3); chk("R5 turn at BOTTOM", 32'(rdData), 1);
    chk("R12 level kept", 32'(waveA), 0);
    chk("R11 enable", 32'(driveA), 1);

    // R6 buffered TOP in fast PWM
    step(1, 3'd0, 8'h07, 0);
    step(1, 3'd1, 8'd0, 0);
    step(1, 3'd2, 8'd10, 0);
    step(0, 3'd2, 0, 0); chk("R1 buffer readback", 32'(rdData), 10);
    ticks(4); chk("R6 old TOP kept", 32'(rdData), 0);
    ticks(5); chk("R6 new TOP active", 32'(rdData), 5);

    // R10 fast PWM set at TOP, clear at match
    step(1, 3'd0, 8'h83, 0);
    step(1, 3'd1, 8'hFE, 0);
    ticks(2); chk("R10 set at TOP", 32'(waveB), 1);
    ticks(1); chk("R10 clear on match", 32'(waveB), 0);

    // R13 reserved mode holds
    step(1, 3'd0, 8'hB4, 0);
    step(1, 3'd4, 8'h07, 0);
    w0 = waveA;
    ticks(3); chk("R13 count held", 32'(rdData), 1);
    chk("R13 wave held", {30'd0, waveB, waveA}, {30'd0, 1'b0, w0});
    step(0, 3'd4, 0, 0); chk("R13 no flags", 32'(rdData), 0);

    // random mix against the model
    for (int i = 0; i < 6000; i++) begin
      int sel;
      if (i % 300 == 0) begin
        r = 8'($urandom);
        if (($urandom % 8) != 0) begin
          if (r[2:0] == 3'd4 || r[2:0] == 3'd6) r[2:0] = r[2:0] + 3'd1;
        end
        step(1, 3'd0, r, 0);
      end else begin
        sel = int'($urandom % 100);
        if (sel < 4)       step(1, 3'(2 + $urandom % 2), 8'($urandom % 40), 1'($urandom % 4 != 0));
        else if (sel < 5)  step(1, 3'd1, 8'($urandom), 1'($urandom % 4 != 0));
        else if (sel < 10) step(1, 3'd4, 8'($urandom), 1'($urandom % 4 != 0));
        else               step(0, 3'($urandom % 6), 8'($urandom), 1'($urandom % 4 != 0));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule